// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked behavioural model of a burst-capable static memory. Each word is split into byte lanes of nine bits (eight data bits and one parity bit, stored as written). An access starts when either of two active-low address strobes is seen on a rising edge. At that edge the chip select is sampled; a selected strobe loads the external address and performs the first access. A two-bit counter then walks the other words of the aligned group of four on each edge where the advance input is low. It follows either a linear order (wrapping count added to the start) or an interleaved order (start XOR count), chosen by a mode input.

The write operation comes from a fixed-priority decode. The global write enable overrides everything. Next, a byte-write enable hands control to the per-lane enables. Anything else is a read. Read data is registered and appears after the edge that performs the access. The data bus drive enable combines that registered read state with two inputs that act without a clock: an active-low output enable and a sleep input. Sleep also starts a wake-up counter. Until it expires, the ready output is low and all accesses are ignored.

The default build holds 1024 words. Setting `ADDR_W` to 16 gives 64K words of 36 bits.

Top module: `burst_sram_core`

## Requirements
- R1: A selected load (either strobe low, `csel_n` low) with a read decode captures `addr_i`. After that edge `rdata_o` holds the stored word, and `drive_o` is high while `oe_n_i` is low.
- R2: When `gwr_n` is low, an access writes all 36 bits of `wdata_i`, whatever `bwe_n` and `lane_we_n` are.
- R3: When `gwr_n` is high and `bwe_n` is low, lane k (bits 9k+8..9k, bit 9k+8 being its parity bit) is written only if `lane_we_n[k]` is low. Other lanes keep their contents. If all four are high, the access is a read.
- R4: When `gwr_n` and `bwe_n` are both high, the access is a read and `lane_we_n` has no effect.
- R5: With `burst_lin_i` high, each edge with `adv_n` low and no strobe accesses the next word. The low two address bits are (start + n) mod 4 and the upper bits are unchanged, so the fifth access returns to the start.
- R6: With `burst_lin_i` low, the low two address bits of the n-th burst access are start XOR (n mod 4).
- R7: A strobe with `csel_n` high deselects the part. Nothing is written, `drive_o` goes low, and advance pulses are ignored until a selected load.
- R8: `drive_o` is low after any write access, and follows `oe_n_i` without waiting for a clock edge.
- R9: While `sleep_i` is high, `drive_o` is low at once, accesses are ignored, and the array and `rdata_o` keep their values. `ready_o` is low after the first edge that sees sleep.
- R10: After sleep returns low, `ready_o` rises after the second edge that sees it low. Accesses before that are ignored.
- R11: An edge with no strobe and `adv_n` high leaves `rdata_o` and `drive_o` unchanged.
- R12: After reset `ready_o` is 1, `drive_o` is 0 and `rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Power-down request, acts on outputs without a clock |
| oe_n_i | input | 1 | Active-low output enable, not clocked |
| burst_lin_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| csel_n | input | 1 | Chip select, active low, sampled with a strobe |
| adv_n | input | 1 | Burst advance, active low |
| addr_i | input | ADDR_W | External word address |
| gwr_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| drive_o | output | 1 | Data bus drive enable |
| ready_o | output | 1 | Awake and accepting accesses |

## Verification
The bench builds the core with `ADDR_W` = 8 and the default four 9-bit lanes and two wake-up cycles. It first fills all 256 words, so every later read has a known value. This small array makes random addresses hit earlier writes often, so partial lane writes, overwrites and burst walks over already-written groups come up many times. Random cycles mix both strobes, deselects, both burst orders, the three write decodes and short sleeps. Directed cases cover the wrap of a burst, decode priority and the wake-up window.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  // Kind of action the core takes on a clock edge.
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STEP  = 2'd2,
    ACC_DESEL = 2'd3
  } acc_kind_e;

  // Next word inside an aligned burst group.
  function automatic logic [7:0] burst_order(input logic [7:0] start,
                                             input logic [7:0] n,
                                             input logic       linear);
    return linear ? (start + n) : (start ^ n);
  endfunction
endpackage

// File: rtl/bsram_wr_decode.sv
module bsram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             gwr_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  output logic [LANES-1:0] lane_wr,
  output logic             is_read
);
  // Fixed priority: global write, then byte-write with lane enables.
  always_comb begin
    if (!gwr_n)      lane_wr = '1;
    else if (!bwe_n) lane_wr = ~lane_we_n;
    else             lane_wr = '0;
    is_read = (lane_wr == '0);
  end
endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_nx;
  logic [7:0]         ord;

  assign cnt_nx = cnt_q + 1'b1;
  assign ord    = burst_order(8'(base_q[BURST_W-1:0]), 8'(cnt_nx), linear);

  always_comb begin
    if (load) acc_addr = addr_in;
    else      acc_addr = {base_q[ADDR_W-1:BURST_W], ord[BURST_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= addr_in;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/bsram_lane_ram.sv
module bsram_lane_ram #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wd,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd <= '0;
    else if (rd_en) rd <= mem[addr];
  end
endmodule

// File: rtl/bsram_wake.sv
module bsram_wake #(
  parameter int WAKE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep,
  output logic ready
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (sleep)         cnt_q <= CNT_W'(WAKE_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsram_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int LANES    = 4,
  parameter int LANE_W   = 9,
  parameter int BURST_W  = 2,
  parameter int WAKE_CYC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sleep_i,
  input  logic                    oe_n_i,
  input  logic                    burst_lin_i,
  input  logic                    cpu_strobe_n,
  input  logic                    ctl_strobe_n,
  input  logic                    csel_n,
  input  logic                    adv_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    gwr_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    drive_o,
  output logic                    ready_o
);
  localparam int DATA_W = LANES * LANE_W;

  logic              ready_q;
  logic              awake;
  logic              strobe;
  logic              active_q;
  logic              rd_valid_q;
  logic              access;
  acc_kind_e         kind;
  logic [LANES-1:0]  lane_wr;
  logic              is_read;
  logic [ADDR_W-1:0] acc_addr;

  assign strobe = !cpu_strobe_n || !ctl_strobe_n;
  assign awake  = ready_q && !sleep_i;

  always_comb begin
    kind = ACC_IDLE;
    if (awake) begin
      if (strobe)                kind = csel_n ? ACC_DESEL : ACC_LOAD;
      else if (active_q && !adv_n) kind = ACC_STEP;
    end
  end

  assign access = (kind == ACC_LOAD) || (kind == ACC_STEP);

  bsram_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk   (clk),
    .rst   (rst),
    .sleep (sleep_i),
    .ready (ready_q)
  );

  bsram_wr_decode #(.LANES(LANES)) u_dec (
    .gwr_n     (gwr_n),
    .bwe_n     (bwe_n),
    .lane_we_n (lane_we_n),
    .lane_wr   (lane_wr),
    .is_read   (is_read)
  );

  bsram_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .load     (kind == ACC_LOAD),
    .step     (kind == ACC_STEP),
    .linear   (burst_lin_i),
    .addr_in  (addr_i),
    .acc_addr (acc_addr)
  );

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      bsram_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .wr_en (access && lane_wr[k]),
        .rd_en (access && is_read),
        .addr  (acc_addr),
        .wd    (wdata_i[k*LANE_W +: LANE_W]),
        .rd    (rdata_o[k*LANE_W +: LANE_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      case (kind)
        ACC_LOAD:  begin active_q <= 1'b1; rd_valid_q <= is_read; end
        ACC_STEP:  rd_valid_q <= is_read;
        ACC_DESEL: begin active_q <= 1'b0; rd_valid_q <= 1'b0; end
        default:   ;
      endcase
    end
  end

  assign drive_o = rd_valid_q && !oe_n_i && awake;
  assign ready_o = ready_q;

  logic unused_w;
  assign unused_w = ^DATA_W;
endmodule

// File: rtl/bsram_checker.sv
module bsram_checker #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep_i,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              csel_n,
  input logic              adv_n,
  input logic              gwr_n,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o,
  input logic              ready_o
);
  logic stb;
  assign stb = !cpu_strobe_n || !ctl_strobe_n;

  assert_sleep_ready_R9: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !ready_o);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i || !ready_o) |=> $stable(rdata_o));

  // Checked against the default two-cycle wake-up.
  assert_wake_low_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_i) |=> !ready_o);

  assert_wake_done_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep_i) ##1 !sleep_i |=> ready_o);

  assert_write_nodrive_R8: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !sleep_i && stb && !csel_n && !gwr_n) |=> !drive_o);

  assert_desel_nodrive_R7: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !sleep_i && stb && csel_n) |=> !drive_o);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !sleep_i && !stb && adv_n) |=> $stable(rdata_o));
endmodule

bind burst_sram_core bsram_checker #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .sleep_i      (sleep_i),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .csel_n       (csel_n),
  .adv_n        (adv_n),
  .gwr_n        (gwr_n),
  .rdata_o      (rdata_o),
  .drive_o      (drive_o),
  .ready_o      (ready_o)
);

// File: tb/sim_burst_sram_core.sv
module sim_burst_sram_core;
  localparam int AW = 8;
  localparam int DW = 36;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sleep_i = 1'b0, oe_n_i = 1'b0, burst_lin_i = 1'b1;
  logic          cpu_strobe_n = 1'b1, ctl_strobe_n = 1'b1, csel_n = 1'b0, adv_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          gwr_n = 1'b1, bwe_n = 1'b1;
  logic [3:0]    lane_we_n = 4'hF;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o, ready_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  burst_sram_core #(.ADDR_W(AW)) u0 (.*);

  // Reference model
  logic [DW-1:0] ref_mem [WORDS];
  bit            m_active = 0, m_rdv = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  logic [DW-1:0] m_rdata = '0;
  int            m_wake = 0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a[3:0], a, a ^ 8'h5a, a + 8'h33, ~a};
  endfunction

  function automatic logic [AW-1:0] nth_addr(input logic [AW-1:0] b,
                                             input logic [1:0] n, input bit lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + n) : (b[1:0] ^ n);
    return {b[AW-1:2], lo};
  endfunction

  task automatic model_edge();
    bit stb, awake, load, desel, step, rd;
    logic [3:0] wl;
    logic [AW-1:0] a;
    stb   = !cpu_strobe_n || !ctl_strobe_n;
    awake = (m_wake == 0) && !sleep_i;
    load  = awake && stb && !csel_n;
    desel = awake && stb && csel_n;
    step  = awake && !stb && m_active && !adv_n;
    if (!gwr_n) wl = 4'hF; else if (!bwe_n) wl = ~lane_we_n; else wl = 4'h0;
    rd = (wl == 4'h0);
    if (load) a = addr_i; else a = nth_addr(m_base, m_cnt + 2'd1, burst_lin_i);
    if (load || step) begin
      for (int k = 0; k < 4; k++)
        if (wl[k]) ref_mem[a][k*9 +: 9] = wdata_i[k*9 +: 9];
      if (rd) m_rdata = ref_mem[a];
      m_rdv = rd;
    end
    if (load) begin m_active = 1; m_base = addr_i; m_cnt = 0; end
    else if (step) m_cnt = m_cnt + 2'd1;
    if (desel) begin m_active = 0; m_rdv = 0; end
    if (rst) begin m_active = 0; m_rdv = 0; m_rdata = '0; m_cnt = 0; m_base = '0; end
    if (rst) m_wake = 0; else if (sleep_i) m_wake = 2; else if (m_wake > 0) m_wake--;
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    bit ed;
    ed = m_rdv && !oe_n_i && (m_wake == 0) && !sleep_i;
    chk(ready_o === (m_wake == 0), {tag, " ready"}, DW'(ready_o), DW'(m_wake == 0));
    chk(drive_o === ed, {tag, " drive"}, DW'(drive_o), DW'(ed));
    if (ed) chk(rdata_o === m_rdata, {tag, " rdata"}, rdata_o, m_rdata);
  endtask

  task automatic idle_in();
    cpu_strobe_n = 1; ctl_strobe_n = 1; adv_n = 1; gwr_n = 1; bwe_n = 1;
    lane_we_n = 4'hF; csel_n = 0;
  endtask

  task automatic load_op(input bit use_cpu, input logic [AW-1:0] a,
                         input bit g, input bit b, input logic [3:0] l,
                         input logic [DW-1:0] d);
    idle_in();
    if (use_cpu) cpu_strobe_n = 0; else ctl_strobe_n = 0;
    addr_i = a; gwr_n = g; bwe_n = b; lane_we_n = l; wdata_i = d;
    tick();
    idle_in();
  endtask

  task automatic adv_read();
    idle_in(); adv_n = 0; tick(); idle_in();
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    void'($urandom(32'h1d5e_ed01));
    @(negedge clk); tick(); tick();
    rst = 0;
    // R12 reset state
    chk(ready_o === 1'b1, "R12 ready", DW'(ready_o), 1);
    chk(drive_o === 1'b0, "R12 drive", DW'(drive_o), 0);
    chk(rdata_o === '0, "R12 rdata", rdata_o, '0);

    for (int a = 0; a < WORDS; a++) load_op(0, AW'(a), 0, 1, 4'hF, pat(AW'(a)));

    // R1 read via processor strobe
    load_op(1, 8'h35, 1, 1, 4'hF, '0);
    chk(rdata_o === pat(8'h35) && drive_o === 1'b1, "R1 read", rdata_o, pat(8'h35));
    // R8 output enable acts without a clock
    oe_n_i = 1; #1;
    chk(drive_o === 1'b0, "R8 oe off", DW'(drive_o), 0);
    oe_n_i = 0; #1;
    chk(drive_o === 1'b1, "R8 oe on", DW'(drive_o), 1);

    // R4 lane enables ignored when both write controls are high
    load_op(0, 8'h36, 1, 1, 4'h0, {DW{1'b1}});
    chk(rdata_o === pat(8'h36), "R4 read", rdata_o, pat(8'h36));

    // R2 global write overrides byte-write
    load_op(0, 8'h37, 0, 0, 4'hF, 36'h9_8765_4321);
    chk(drive_o === 1'b0, "R8 after write", DW'(drive_o), 0);
    load_op(0, 8'h37, 1, 1, 4'hF, '0);
    chk(rdata_o === 36'h9_8765_4321, "R2 global", rdata_o, 36'h9_8765_4321);

    // R3 lanes 0 and 2 written, parity included
    load_op(0, 8'h38, 1, 0, 4'b1010, {9'h1AA, 9'h1BB, 9'h1CC, 9'h1DD});
    load_op(0, 8'h38, 1, 0, 4'hF, '0);
    held = pat(8'h38);
    held[8:0] = 9'h1DD; held[26:18] = 9'h1BB;
    chk(rdata_o === held, "R3 lanes", rdata_o, held);

    // R5 linear burst from low bits 2, wraps to start
    burst_lin_i = 1;
    load_op(1, 8'h42, 1, 1, 4'hF, '0);
    chk(rdata_o === pat(8'h42), "R5 first", rdata_o, pat(8'h42));
    adv_read(); chk(rdata_o === pat(8'h43), "R5 second", rdata_o, pat(8'h43));
    adv_read(); chk(rdata_o === pat(8'h40), "R5 third", rdata_o, pat(8'h40));
    adv_read(); chk(rdata_o === pat(8'h41), "R5 fourth", rdata_o, pat(8'h41));
    adv_read(); chk(rdata_o === pat(8'h42), "R5 wrap", rdata_o, pat(8'h42));

    // R6 interleaved burst from low bits 1
    burst_lin_i = 0;
    load_op(1, 8'h51, 1, 1, 4'hF, '0);
    adv_read(); chk(rdata_o === pat(8'h50), "R6 second", rdata_o, pat(8'h50));
    adv_read(); chk(rdata_o === pat(8'h53), "R6 third", rdata_o, pat(8'h53));
    adv_read(); chk(rdata_o === pat(8'h52), "R6 fourth", rdata_o, pat(8'h52));

    // R11 idle edges keep data
    held = rdata_o;
    tick(); tick();
    chk(rdata_o === held && drive_o === 1'b1, "R11 idle", rdata_o, held);

    // R7 deselected strobe then advances, and a write attempt
    idle_in(); cpu_strobe_n = 0; csel_n = 1; gwr_n = 0; addr_i = 8'h60;
    wdata_i = '0; tick(); idle_in();
    chk(drive_o === 1'b0, "R7 desel", DW'(drive_o), 0);
    adv_read(); adv_read();
    chk(drive_o === 1'b0 && rdata_o === held, "R7 adv ignored", rdata_o, held);
    load_op(0, 8'h60, 1, 1, 4'hF, '0);
    chk(rdata_o === pat(8'h60), "R7 no write", rdata_o, pat(8'h60));

    // R9 sleep and R10 wake-up
    sleep_i = 1; #1;
    chk(drive_o === 1'b0, "R9 drive off", DW'(drive_o), 0);
    held = rdata_o;
    ctl_strobe_n = 0; gwr_n = 0; addr_i = 8'h61; wdata_i = '0; tick();
    chk(ready_o === 1'b0 && rdata_o === held, "R9 asleep", rdata_o, held);
    sleep_i = 0; tick();
    chk(ready_o === 1'b0, "R10 wake 1", DW'(ready_o), 0);
    tick();
    chk(ready_o === 1'b1, "R10 wake 2", DW'(ready_o), 1);
    load_op(0, 8'h61, 1, 1, 4'hF, '0);
    chk(rdata_o === pat(8'h61), "R9 array kept", rdata_o, pat(8'h61));

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      cpu_strobe_n = ($urandom % 8) != 0;
      ctl_strobe_n = ($urandom % 8) != 0;
      csel_n       = ($urandom % 7) == 0;
      adv_n        = $urandom % 2;
      gwr_n        = ($urandom % 6) != 0;
      bwe_n        = ($urandom % 4) != 0;
      lane_we_n    = 4'($urandom);
      addr_i       = AW'($urandom);
      wdata_i      = {4'($urandom), 32'($urandom)};
      burst_lin_i  = $urandom % 2;
      oe_n_i       = ($urandom % 5) == 0;
      sleep_i      = ($urandom % 60) == 0;
      tick();
      check_all("R1-mix");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule